// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block interprets host bus writes for a byte-wide parallel flash that guards every alteration behind a software unlock pattern. The host strobes chip-enable and write-enable low with output-enable high. The decoder captures the address at the start of the strobe and the data byte at its end. Strobes shorter than a set number of clock cycles are discarded as glitches. Each accepted write is compared against the expected step of a multi-write sequence. A complete sequence yields a one-cycle request to the memory model: program a byte, erase a 4 KB sector, erase the whole chip, enter identification mode or leave it. Any write that does not match the expected step silently drops the decoder back to normal read mode.

While identification mode is active, reads at address 0 and 1 return the manufacturer and device codes instead of array data. All other addresses still return array data. The memory model raises `busy` while it works. Writes arriving during that time are dropped, so an identification exit cannot take effect then.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: A write is recognised only while `ce_n` and `we_n` are both low and `oe_n` is high. A strobe made with `oe_n` low has no effect on the sequence.
- R2: A write strobe that is seen active on fewer than `MIN_PULSE` rising clock edges (default 3) is discarded. A strobe of exactly `MIN_PULSE` edges is accepted.
- R3: The address is taken on the first edge of an active strobe. The data byte is taken on the first edge at which the strobe is seen inactive. Values driven at other times do not matter.
- R4: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by any write D@A produce a one-cycle `req_program` with `req_addr`=A and `req_data`=D. The pulse is visible after the second rising edge following the end of the strobe.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address A, produce a one-cycle `req_erase_sector`. In that pulse `req_addr` is A with bits 11..0 cleared.
- R6: The same five-write prefix followed by 10h@5555h produces a one-cycle `req_erase_chip`. 10h at any other address produces nothing.
- R7: AAh@5555h, 55h@2AAAh, 90h@5555h pulses `req_id_enter` and sets `id_active`. While it is set, `rd_data` is BFh at address 0 and `DEV_ID` (default D7h) at address 1. Every other address, and every address outside identification mode, returns `array_rdata`.
- R8: Identification mode is left by a single F0h write to any address, or by AAh@5555h, 55h@2AAAh, F0h@5555h. Either pulses `req_id_exit` and clears `id_active`.
- R9: A write that does not match the expected step, in data or address, returns the decoder to idle. The rest of that sequence then produces no request.
- R10: Command addresses are compared on bits 14..0 only. Higher address bits are ignored.
- R11: A write completed while `busy` is high is discarded and leaves the sequence position unchanged. In particular, F0h then does not clear `id_active`.
- R12: At most one request output is high in any cycle, and no request stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Host address bus |
| bus_din | input | 8 | Host write data |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Memory model is programming or erasing |
| array_rdata | input | 8 | Array data for the current address |
| rd_data | output | 8 | Read data to the host |
| id_active | output | 1 | Identification mode is active |
| req_program | output | 1 | One-cycle byte program request |
| req_erase_sector | output | 1 | One-cycle sector erase request |
| req_erase_chip | output | 1 | One-cycle chip erase request |
| req_id_enter | output | 1 | One-cycle identification entry |
| req_id_exit | output | 1 | One-cycle identification exit |
| req_addr | output | ADDR_W | Target address of the request |
| req_data | output | 8 | Data byte for a program request |

## Verification
Two things can meet in one cycle: the final write of a sequence being handed to the sequencer, and `busy` rising. The bench provokes this by raising `busy` on the falling edge just after the target write's strobe ends, so busy and the write's hand-off land on the same sequencer edge. It then judges that no program request appears, and that a later write made after `busy` falls becomes the program target because the sequence position was kept. A second collision is checked the same way: `busy` held high while an F0h exit write completes, after which the identification codes must still be readable.

// File: rtl/ucd_pkg.sv
// Package: shared command codes, command addresses and sequencer states
// for the unlock-sequence command decoder. Assumes 15-bit command address
// compare and byte-wide data.
package ucd_pkg;

    localparam int CMD_ADDR_W = 15;

    localparam logic [CMD_ADDR_W-1:0] ADR_UNL_A = 15'h5555;
    localparam logic [CMD_ADDR_W-1:0] ADR_UNL_B = 15'h2AAA;

    localparam logic [7:0] KEY_A       = 8'hAA;
    localparam logic [7:0] KEY_B       = 8'h55;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_ID_ENTER = 8'h90;
    localparam logic [7:0] OP_ID_EXIT  = 8'hF0;
    localparam logic [7:0] OP_SECTOR   = 8'h30;
    localparam logic [7:0] OP_CHIP     = 8'h10;

    localparam logic [7:0] MFR_CODE    = 8'hBF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PGM_TGT,
        ST_ERA1,
        ST_ERA2,
        ST_ERA3
    } seq_state_t;

endpackage

// File: rtl/ucd_strobe_capture.sv
// Module: ucd_strobe_capture
// Turns sampled host strobes into one-cycle write events. A write is active
// while ce_n and we_n are low and oe_n is high. Address is taken on the first
// active edge, data on the first inactive edge. Strobes seen active on fewer
// than MIN_PULSE edges are dropped. Assumes strobes are already synchronous.
module ucd_strobe_capture #(
    parameter int ADDR_W    = 19,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1) < 1 ? 1 : $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_PULSE);

    logic             wr_active;
    logic             active_q;
    logic [CNT_W-1:0] width_cnt;

    // Qualified write strobe.
    always_comb wr_active = !ce_n && !we_n && oe_n;

    // Track strobe edges, count its width, latch address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            width_cnt <= '0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            active_q <= wr_active;
            wr_valid <= 1'b0;
            if (wr_active && !active_q) begin
                wr_addr   <= bus_addr;
                width_cnt <= CNT_W'(1);
            end else if (wr_active && width_cnt < CNT_MIN) begin
                width_cnt <= width_cnt + CNT_W'(1);
            end
            if (!wr_active && active_q) begin
                wr_valid <= (width_cnt >= CNT_MIN);
                wr_data  <= bus_din;
            end
        end
    end

endmodule

// File: rtl/ucd_sequencer.sv
// Module: ucd_sequencer
// Walks the unlock sequences on accepted write events and issues registered
// one-cycle requests. A wrong step returns to idle. Events while busy is
// high are dropped with the state kept. Holds the identification-mode flag.
module ucd_sequencer
    import ucd_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              req_program,
    output logic              req_erase_sector,
    output logic              req_erase_chip,
    output logic              req_id_enter,
    output logic              req_id_exit,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data,
    output logic              id_active
);
    localparam int SECT_LSB = $clog2(SECTOR_BYTES);

    seq_state_t              state, nxt_state;
    logic                    nxt_id;
    logic                    do_prog, do_sect, do_chip, do_enter, do_exit;
    logic [CMD_ADDR_W-1:0]   cmd_addr;
    logic                    at_a, at_b, key_a_hit, key_b_hit;
    logic [ADDR_W-1:0]       sect_base;

    // Compare only the low command-address bits.
    always_comb begin
        cmd_addr  = wr_addr[CMD_ADDR_W-1:0];
        at_a      = (cmd_addr == ADR_UNL_A);
        at_b      = (cmd_addr == ADR_UNL_B);
        key_a_hit = at_a && (wr_data == KEY_A);
        key_b_hit = at_b && (wr_data == KEY_B);
        sect_base = {wr_addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
    end

    // Next-state and request decode for one accepted write.
    always_comb begin
        nxt_state = state;
        nxt_id    = id_active;
        do_prog   = 1'b0;
        do_sect   = 1'b0;
        do_chip   = 1'b0;
        do_enter  = 1'b0;
        do_exit   = 1'b0;
        if (wr_valid && !busy) begin
            nxt_state = ST_IDLE;
            unique case (state)
                ST_IDLE: begin
                    if (key_a_hit)                 nxt_state = ST_KEY1;
                    else if (wr_data == OP_ID_EXIT) do_exit = 1'b1;
                end
                ST_KEY1: if (key_b_hit) nxt_state = ST_KEY2;
                ST_KEY2: begin
                    if (at_a) begin
                        unique case (wr_data)
                            OP_PROGRAM:  nxt_state = ST_PGM_TGT;
                            OP_ERASE:    nxt_state = ST_ERA1;
                            OP_ID_ENTER: do_enter  = 1'b1;
                            OP_ID_EXIT:  do_exit   = 1'b1;
                            default:     nxt_state = ST_IDLE;
                        endcase
                    end
                end
                ST_PGM_TGT: do_prog = 1'b1;
                ST_ERA1: if (key_a_hit) nxt_state = ST_ERA2;
                ST_ERA2: if (key_b_hit) nxt_state = ST_ERA3;
                ST_ERA3: begin
                    if (wr_data == OP_SECTOR)           do_sect = 1'b1;
                    else if (at_a && wr_data == OP_CHIP) do_chip = 1'b1;
                end
                default: nxt_state = ST_IDLE;
            endcase
            if (do_enter) nxt_id = 1'b1;
            if (do_exit)  nxt_id = 1'b0;
        end
    end

    // Register state, mode flag and the one-cycle requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state            <= ST_IDLE;
            id_active        <= 1'b0;
            req_program      <= 1'b0;
            req_erase_sector <= 1'b0;
            req_erase_chip   <= 1'b0;
            req_id_enter     <= 1'b0;
            req_id_exit      <= 1'b0;
            req_addr         <= '0;
            req_data         <= '0;
        end else begin
            state            <= nxt_state;
            id_active        <= nxt_id;
            req_program      <= do_prog;
            req_erase_sector <= do_sect;
            req_erase_chip   <= do_chip;
            req_id_enter     <= do_enter;
            req_id_exit      <= do_exit;
            if (do_prog || do_chip || do_enter || do_exit) begin
                req_addr <= wr_addr;
                req_data <= wr_data;
            end else if (do_sect) begin
                req_addr <= sect_base;
                req_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/ucd_read_mux.sv
// Module: ucd_read_mux
// Selects read data. In identification mode, address 0 returns the
// manufacturer code and address 1 the device code; all else is array data.
module ucd_read_mux
    import ucd_pkg::*;
#(
    parameter int         ADDR_W = 19,
    parameter logic [7:0] DEV_ID = 8'hD7
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              id_active,
    input  logic [7:0]        array_rdata,
    output logic [7:0]        rd_data
);
    logic id_window;

    // Choose between identification codes and array data.
    always_comb begin
        id_window = id_active && (bus_addr[ADDR_W-1:1] == '0);
        if (!id_window)       rd_data = array_rdata;
        else if (bus_addr[0]) rd_data = DEV_ID;
        else                  rd_data = MFR_CODE;
    end

endmodule

// File: rtl/unlock_cmd_decoder.sv
// Module: unlock_cmd_decoder (top)
// Command interpreter of a byte-wide flash guarded by unlock sequences:
// strobe capture with glitch rejection, the unlock sequencer and the read
// mux. Assumes all host inputs are synchronous to clk. ADDR_W must be >= 15.
module unlock_cmd_decoder #(
    parameter int         ADDR_W       = 19,
    parameter int         MIN_PULSE    = 3,
    parameter int         SECTOR_BYTES = 4096,
    parameter logic [7:0] DEV_ID       = 8'hD7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic [7:0]        array_rdata,
    output logic [7:0]        rd_data,
    output logic              id_active,
    output logic              req_program,
    output logic              req_erase_sector,
    output logic              req_erase_chip,
    output logic              req_id_enter,
    output logic              req_id_exit,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data
);
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    ucd_strobe_capture #(
        .ADDR_W    (ADDR_W),
        .MIN_PULSE (MIN_PULSE)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_din  (bus_din),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    ucd_sequencer #(
        .ADDR_W       (ADDR_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_valid         (wr_valid),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .busy             (busy),
        .req_program      (req_program),
        .req_erase_sector (req_erase_sector),
        .req_erase_chip   (req_erase_chip),
        .req_id_enter     (req_id_enter),
        .req_id_exit      (req_id_exit),
        .req_addr         (req_addr),
        .req_data         (req_data),
        .id_active        (id_active)
    );

    ucd_read_mux #(
        .ADDR_W (ADDR_W),
        .DEV_ID (DEV_ID)
    ) u_rd (
        .bus_addr    (bus_addr),
        .id_active   (id_active),
        .array_rdata (array_rdata),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/ucd_checker.sv
// Module: ucd_checker
// Port-level properties of the command decoder, bound to the top module.
module ucd_checker #(
    parameter int ADDR_W       = 19,
    parameter int SECTOR_BYTES = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              req_program,
    input logic              req_erase_sector,
    input logic              req_erase_chip,
    input logic              req_id_enter,
    input logic              req_id_exit,
    input logic [ADDR_W-1:0] req_addr,
    input logic              id_active
);
    localparam int SECT_LSB = $clog2(SECTOR_BYTES);

    logic [4:0] req_vec;
    logic       req_any;

    // Gather the request outputs.
    always_comb begin
        req_vec = {req_program, req_erase_sector, req_erase_chip, req_id_enter, req_id_exit};
        req_any = |req_vec;
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec)); // R12

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |=> !req_any); // R12

    AST_NO_REQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |-> !$past(busy)); // R11

    AST_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_erase_sector |-> (req_addr[SECT_LSB-1:0] == '0)); // R5

    AST_ID_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        req_id_enter |-> id_active); // R7

    AST_ID_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        req_id_exit |-> !id_active); // R8

    AST_ID_CHANGE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_active) |-> (req_id_enter || req_id_exit)); // R8

endmodule

bind unlock_cmd_decoder ucd_checker #(
    .ADDR_W       (ADDR_W),
    .SECTOR_BYTES (SECTOR_BYTES)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .busy             (busy),
    .req_program      (req_program),
    .req_erase_sector (req_erase_sector),
    .req_erase_chip   (req_erase_chip),
    .req_id_enter     (req_id_enter),
    .req_id_exit      (req_id_exit),
    .req_addr         (req_addr),
    .id_active        (id_active)
);

// File: tb/sim_unlock_cmd_decoder.sv
`timescale 1ns/1ps
// Directed bench for unlock_cmd_decoder: one task per scenario.
module sim_unlock_cmd_decoder;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_din = '0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
    logic [7:0]    array_rdata = 8'h3C;
    logic [7:0]    rd_data;
    logic          id_active;
    logic          req_program, req_erase_sector, req_erase_chip, req_id_enter, req_id_exit;
    logic [AW-1:0] req_addr;
    logic [7:0]    req_data;

    int n_chk = 0, n_bad = 0;
    int c_prog = 0, c_sect = 0, c_chip = 0, c_in = 0, c_out = 0;
    int pcnt = 0, l_pcnt = 0, rel_pcnt = 0;
    logic [AW-1:0] l_addr = '0;
    logic [7:0]    l_data = '0;
    bit done = 0;

    always #4 clk = ~clk;

    unlock_cmd_decoder #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy(busy),
        .array_rdata(array_rdata), .rd_data(rd_data), .id_active(id_active),
        .req_program(req_program), .req_erase_sector(req_erase_sector),
        .req_erase_chip(req_erase_chip), .req_id_enter(req_id_enter),
        .req_id_exit(req_id_exit), .req_addr(req_addr), .req_data(req_data)
    );

    always @(posedge clk) pcnt <= pcnt + 1;

    // Request monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (req_program)      c_prog++;
        if (req_erase_sector) c_sect++;
        if (req_erase_chip)   c_chip++;
        if (req_id_enter)     c_in++;
        if (req_id_exit)      c_out++;
        if (req_program || req_erase_sector || req_erase_chip || req_id_enter || req_id_exit) begin
            l_addr = req_addr;
            l_data = req_data;
            l_pcnt = pcnt;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One host write: address valid at strobe start, data valid at its end.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input int w = 4, input bit oe_low = 0, input bit busy_end = 0);
        @(negedge clk);
        bus_addr = a; bus_din = 8'h00; ce_n = 0; we_n = 0; oe_n = oe_low ? 1'b0 : 1'b1;
        @(negedge clk);
        bus_addr = ~a; bus_din = d;
        repeat (w - 1) @(negedge clk);
        we_n = 1; ce_n = 1; rel_pcnt = pcnt;
        @(negedge clk);
        bus_din = ~d; oe_n = 1;
        if (busy_end) busy = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic unlock3(input logic [7:0] op);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, op);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12 reset no request", {req_program, req_erase_sector, req_erase_chip, req_id_enter, req_id_exit}, 0);
        chk("R7 reset id_active", id_active, 0);
        bus_addr = 0;
        @(negedge clk);
        chk("R7 reset read array", rd_data, 8'h3C);
    endtask

    task automatic t_program;
        int p0 = c_prog;
        unlock3(8'hA0);
        wr(19'h4_1234, 8'h5A);
        chk("R4 program count", c_prog - p0, 1);
        chk("R3 program addr from strobe start", l_addr, 19'h4_1234);
        chk("R3 program data from strobe end", l_data, 8'h5A);
        chk("R4 program latency", l_pcnt - rel_pcnt, 2);
    endtask

    task automatic t_glitch;
        int p0 = c_prog;
        wr(19'h05555, 8'hAA, 2);
        wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00100, 8'h11);
        chk("R2 short strobe dropped", c_prog - p0, 0);
        wr(19'h05555, 8'hAA, 3); wr(19'h02AAA, 8'h55, 3); wr(19'h05555, 8'hA0, 3);
        wr(19'h00100, 8'h22, 3);
        chk("R2 strobe of exact minimum accepted", c_prog - p0, 1);
    endtask

    task automatic t_oe_inhibit;
        int p0 = c_prog;
        wr(19'h05555, 8'hAA, 4, 1);
        wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00200, 8'h33);
        chk("R1 oe low write ignored", c_prog - p0, 0);
    endtask

    task automatic erase_prefix;
        unlock3(8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
    endtask

    task automatic t_sector;
        int s0 = c_sect;
        erase_prefix();
        wr(19'h5_2345, 8'h30);
        chk("R5 sector erase count", c_sect - s0, 1);
        chk("R5 sector address aligned", l_addr, 19'h5_2000);
    endtask

    task automatic t_chip;
        int c0 = c_chip;
        erase_prefix();
        wr(19'h01234, 8'h10);
        chk("R6 chip erase wrong address", c_chip - c0, 0);
        erase_prefix();
        wr(19'h05555, 8'h10);
        chk("R6 chip erase count", c_chip - c0, 1);
    endtask

    task automatic t_id;
        int i0 = c_in, o0 = c_out;
        unlock3(8'h90);
        chk("R7 id entry request", c_in - i0, 1);
        chk("R7 id_active set", id_active, 1);
        bus_addr = 0; @(negedge clk);
        chk("R7 id read manufacturer", rd_data, 8'hBF);
        bus_addr = 1; @(negedge clk);
        chk("R7 id read device", rd_data, 8'hD7);
        bus_addr = 2; @(negedge clk);
        chk("R7 id other address array", rd_data, 8'h3C);
        wr(19'h01234, 8'hF0);
        chk("R8 single exit request", c_out - o0, 1);
        bus_addr = 0; @(negedge clk);
        chk("R8 single exit read array", rd_data, 8'h3C);
        unlock3(8'h90);
        unlock3(8'hF0);
        chk("R8 three-write exit request", c_out - o0, 2);
        chk("R8 three-write exit clears mode", id_active, 0);
    endtask

    task automatic t_abort;
        int p0 = c_prog, i0 = c_in;
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h00);
        wr(19'h05555, 8'hA0); wr(19'h00300, 8'h44);
        chk("R9 wrong data aborts", c_prog - p0, 0);
        wr(19'h05555, 8'hAA); wr(19'h01234, 8'h55); wr(19'h05555, 8'h90);
        chk("R9 wrong address aborts", c_in - i0, 0);
        chk("R9 no id mode after abort", id_active, 0);
    endtask

    task automatic t_upper_bits;
        int p0 = c_prog;
        wr(19'h7D555, 8'hAA); wr(19'h7AAAA, 8'h55); wr(19'h1D555, 8'hA0);
        wr(19'h6_0042, 8'h66);
        chk("R10 upper address bits ignored", c_prog - p0, 1);
        chk("R10 target keeps upper bits", l_addr, 19'h6_0042);
    endtask

    task automatic t_busy;
        int p0 = c_prog, o0 = c_out;
        unlock3(8'hA0);
        wr(19'h00500, 8'h77, 4, 0, 1);
        chk("R11 write at busy rise dropped", c_prog - p0, 0);
        busy = 0;
        wr(19'h00600, 8'h88);
        chk("R11 sequence position kept", c_prog - p0, 1);
        chk("R11 later write is target", l_data, 8'h88);
        unlock3(8'h90);
        busy = 1;
        wr(19'h00000, 8'hF0);
        chk("R11 exit ignored while busy", c_out - o0, 0);
        bus_addr = 0; @(negedge clk);
        chk("R11 id codes still readable", rd_data, 8'hBF);
        busy = 0;
        wr(19'h00000, 8'hF0);
        chk("R8 exit after busy", id_active, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_program();
        t_glitch();
        t_oe_inhibit();
        t_sector();
        t_chip();
        t_id();
        t_abort();
        t_upper_bits();
        t_busy();
        chk("R12 no stray chip erase", c_chip, 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R12 act=timeout exp=complete");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule